// File: doc/BRIEF.md
# Vertical 5/3 Lifting Stage with Column State Memory

This block performs the column (vertical) pass of a separable two-dimensional integer 5/3 lifting wavelet transform for one decomposition level. It receives the output of a row filter as a stream of samples, one per cycle when `in_valid` is high, in raster order. Within an image line, each column contributes two consecutive samples: its horizontal high-band value first, then its horizontal low-band value. `in_sof` marks the first sample of a frame.

The block does not store whole rows of the picture. It keeps three line memories with one entry per line sample. The first holds the latest odd line until the following even line arrives. The second holds the previous even line. The third holds the previous high-pass result of each sample position. All three are read one cycle ahead of use and are written as each sample passes. Each time an even line (from the third line on) or the final line arrives, the block produces one vertical high-pass and one vertical low-pass value per sample in the same cycle. Each lane carries a two-bit code that names the subband.

Top module: `dwt_col_lift53`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` stays low until an accepted frame produces a result.
- R2: Lines are `IMG_W` samples long; even positions carry the high band, odd positions the low band; a frame is `IMG_H` lines. A valid sample with `in_sof` high starts a frame. Valid samples are ignored, with no output and no state change, while no frame is active (before the first start, or after the last sample of a frame).
- R3: A start marker in the middle of a frame abandons the old frame; the results then equal those of the new frame alone.
- R4: For pair k and sample position i, the high output is d = x(2k+1) − floor((x(2k) + x(2k+2)) / 2).
- R5: The low output is s = x(2k) + floor((d(k−1) + d(k) + 2) / 4), with floor taken toward minus infinity.
- R6: For the first pair (k = 0), d(−1) is replaced by d(0).
- R7: For the last pair, x(IMG_H) is replaced by x(IMG_H−2), and that pair is produced while the final line is streaming.
- R8: The high and low results appear together. Codes: HH=0 and HL=1 for high-band samples; LH=2 and LL=3 for low-band samples. `out_hi_code` carries 0 or 2, and `out_lo_code` equals `out_hi_code` + 1.
- R9: Results come out pair by pair and, within a pair, in sample position order, so HH/HL for a column always come just before that column's LH/LL. A frame yields exactly IMG_H/2 × IMG_W results. Lines 0 and the non-final odd lines produce none.
- R10: A result appears on the second rising edge after its triggering sample is accepted. Idle cycles between samples are allowed and do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_sof | input | 1 | First sample of a frame |
| in_data | input | DW | Signed row-filter result |
| out_valid | output | 1 | Result pair present |
| out_hi | output | DW+2 | Signed vertical high-pass value |
| out_lo | output | DW+2 | Signed vertical low-pass value |
| out_hi_code | output | 2 | Subband code of `out_hi` |
| out_lo_code | output | 2 | Subband code of `out_lo` |

## Verification
A flat frame gives zero high-pass values and unchanged low-pass values. This shows that the two lanes and their codes are not swapped. A frame that rises linearly down each column gives zero high-pass values everywhere except the last pair. That separates the top extension rule from the bottom one, and hand-computed values pin both. A small pattern of negative values tells floor rounding apart from truncation. A frame of random signed values is checked against a model written from the lifting equations. The same frame is then sent with idle gaps, and again after stray samples and an abandoned partial frame. These runs show that timing gaps, ignored samples and restarts leave the results untouched.

// File: rtl/dwt_col_pkg.sv
package dwt_col_pkg;

    typedef enum logic [1:0] {
        SB_HH = 2'd0,
        SB_HL = 2'd1,
        SB_LH = 2'd2,
        SB_LL = 2'd3
    } subband_e;

    // role of an incoming line within the frame
    typedef enum logic [1:0] {
        RK_SEED = 2'd0,   // line 0: only seeds the even memory
        RK_HOLD = 2'd1,   // odd line, parked until the next even line
        RK_PAIR = 2'd2,   // even line >= 2: closes a pair
        RK_LAST = 2'd3    // final (odd) line: closes the last pair
    } rowkind_e;

endpackage

// File: rtl/dwt_col_ram.sv
module dwt_col_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 12,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/dwt_col_seq.sv
module dwt_col_seq
    import dwt_col_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 64,
    localparam int IW   = $clog2(IMG_W),
    localparam int RW   = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    output logic          acc,
    output logic [IW-1:0] idx,
    output rowkind_e      kind,
    output logic          first_pair
);

    localparam logic [IW-1:0] IDX_LAST = IW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
    localparam logic [RW-1:0] ROW_TWO  = RW'(2);

    typedef struct packed {
        logic          active;
        logic [IW-1:0] idx;
        logic [RW-1:0] row;
    } seq_t;

    seq_t st_d, st_q;
    logic          start;
    logic [IW-1:0] cur_idx;
    logic [RW-1:0] cur_row;

    always_comb begin
        st_d    = st_q;
        start   = in_valid && in_sof;
        cur_idx = start ? '0 : st_q.idx;
        cur_row = start ? '0 : st_q.row;
        acc     = in_valid && (start || st_q.active);

        if (cur_row == '0) begin
            kind = RK_SEED;
        end else if (cur_row == ROW_LAST) begin
            kind = RK_LAST;
        end else if (cur_row[0]) begin
            kind = RK_HOLD;
        end else begin
            kind = RK_PAIR;
        end
        first_pair = (cur_row == ROW_TWO);
        idx        = cur_idx;

        if (acc) begin
            st_d.active = 1'b1;
            if (cur_idx == IDX_LAST) begin
                st_d.idx = '0;
                if (cur_row == ROW_LAST) begin
                    st_d.row    = '0;
                    st_d.active = 1'b0;
                end else begin
                    st_d.row = cur_row + RW'(1);
                end
            end else begin
                st_d.idx = cur_idx + IW'(1);
                st_d.row = cur_row;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dwt_col_lift.sv
module dwt_col_lift
    import dwt_col_pkg::*;
#(
    parameter int DW = 12,
    localparam int OW = DW + 2,
    localparam int CW = DW + 4
) (
    input  rowkind_e               kind,
    input  logic                   first_pair,
    input  logic signed [DW-1:0]   x_new,
    input  logic signed [DW-1:0]   x_odd_mem,
    input  logic signed [DW-1:0]   x_even_mem,
    input  logic signed [OW-1:0]   d_prev_mem,
    output logic signed [OW-1:0]   hi,
    output logic signed [OW-1:0]   lo
);

    localparam logic signed [CW-1:0] TWO = CW'(2);

    logic signed [CW-1:0] x_odd, x_top, x_bot, d_cur, d_old, s_cur;

    always_comb begin
        // the final line is odd: mirror the even line above it
        x_top = CW'(x_even_mem);
        if (kind == RK_LAST) begin
            x_odd = CW'(x_new);
            x_bot = CW'(x_even_mem);
        end else begin
            x_odd = CW'(x_odd_mem);
            x_bot = CW'(x_new);
        end
        d_cur = x_odd - ((x_top + x_bot) >>> 1);
        d_old = first_pair ? d_cur : CW'(d_prev_mem);
        s_cur = x_top + ((d_old + d_cur + TWO) >>> 2);
        hi    = d_cur[OW-1:0];
        lo    = s_cur[OW-1:0];
    end

endmodule

// File: rtl/dwt_col_lift53.sv
module dwt_col_lift53
    import dwt_col_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 64,
    parameter int DW    = 12,
    localparam int OW   = DW + 2,
    localparam int IW   = $clog2(IMG_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic signed [DW-1:0] in_data,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_hi,
    output logic signed [OW-1:0] out_lo,
    output logic [1:0]           out_hi_code,
    output logic [1:0]           out_lo_code
);

    typedef struct packed {
        logic                 s1_v;
        rowkind_e             s1_kind;
        logic                 s1_first;
        logic [IW-1:0]        s1_idx;
        logic signed [DW-1:0] s1_x;
        logic                 o_v;
        logic signed [OW-1:0] o_hi;
        logic signed [OW-1:0] o_lo;
        subband_e             o_hcode;
        subband_e             o_lcode;
    } pipe_t;

    pipe_t st_d, st_q;

    logic          seq_acc, seq_first;
    logic [IW-1:0] seq_idx;
    rowkind_e      seq_kind;

    logic [DW-1:0] odd_rd, even_rd;
    logic [OW-1:0] dlt_rd;
    logic          odd_we, even_we, dlt_we;
    logic signed [OW-1:0] lift_hi, lift_lo;

    dwt_col_seq #(.IMG_W(IMG_W), .IMG_H(IMG_H)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .acc        (seq_acc),
        .idx        (seq_idx),
        .kind       (seq_kind),
        .first_pair (seq_first)
    );

    dwt_col_ram #(.DEPTH(IMG_W), .WIDTH(DW)) odd_ram_i (
        .clk(clk), .we(odd_we), .waddr(st_q.s1_idx), .wdata(st_q.s1_x),
        .raddr(seq_idx), .rdata(odd_rd)
    );

    dwt_col_ram #(.DEPTH(IMG_W), .WIDTH(DW)) even_ram_i (
        .clk(clk), .we(even_we), .waddr(st_q.s1_idx), .wdata(st_q.s1_x),
        .raddr(seq_idx), .rdata(even_rd)
    );

    dwt_col_ram #(.DEPTH(IMG_W), .WIDTH(OW)) dlt_ram_i (
        .clk(clk), .we(dlt_we), .waddr(st_q.s1_idx), .wdata(lift_hi),
        .raddr(seq_idx), .rdata(dlt_rd)
    );

    dwt_col_lift #(.DW(DW)) lift_i (
        .kind       (st_q.s1_kind),
        .first_pair (st_q.s1_first),
        .x_new      (st_q.s1_x),
        .x_odd_mem  (odd_rd),
        .x_even_mem (even_rd),
        .d_prev_mem (dlt_rd),
        .hi         (lift_hi),
        .lo         (lift_lo)
    );

    always_comb begin
        st_d = st_q;

        // stage 1: sample waits one cycle for the line memories
        st_d.s1_v     = seq_acc;
        st_d.s1_kind  = seq_kind;
        st_d.s1_first = seq_first;
        st_d.s1_idx   = seq_idx;
        st_d.s1_x     = in_data;

        even_we = st_q.s1_v && (st_q.s1_kind == RK_SEED || st_q.s1_kind == RK_PAIR);
        odd_we  = st_q.s1_v && (st_q.s1_kind == RK_HOLD);
        dlt_we  = st_q.s1_v && (st_q.s1_kind == RK_PAIR);

        // stage 2: result register
        st_d.o_v  = st_q.s1_v && (st_q.s1_kind == RK_PAIR || st_q.s1_kind == RK_LAST);
        st_d.o_hi = lift_hi;
        st_d.o_lo = lift_lo;
        if (st_q.s1_idx[0]) begin
            st_d.o_hcode = SB_LH;
            st_d.o_lcode = SB_LL;
        end else begin
            st_d.o_hcode = SB_HH;
            st_d.o_lcode = SB_HL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.o_v;
    assign out_hi      = st_q.o_hi;
    assign out_lo      = st_q.o_lo;
    assign out_hi_code = st_q.o_hcode;
    assign out_lo_code = st_q.o_lcode;

endmodule

// File: rtl/dwt_col_lift53_chk.sv
module dwt_col_lift53_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic [1:0] out_hi_code,
    input logic [1:0] out_lo_code
);

    logic last_hh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_hh_q <= 1'b0;
        end else if (out_valid) begin
            last_hh_q <= (out_hi_code == 2'd0);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!out_valid);
        end
    end

    assert_code_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_hi_code[0] && out_lo_code == out_hi_code + 2'd1));

    assert_lh_follows_hh_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hi_code == 2'd2) |-> last_hh_q);

    assert_two_edge_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

endmodule

bind dwt_col_lift53 dwt_col_lift53_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_hi_code (out_hi_code),
    .out_lo_code (out_lo_code)
);

// File: tb/dwt_col_lift53_tb_top.sv
module dwt_col_lift53_tb_top;

    localparam int W  = 8;
    localparam int H  = 6;
    localparam int DW = 10;
    localparam int OW = DW + 2;
    localparam int NOUT = (H / 2) * W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_sof = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_hi, out_lo;
    logic [1:0]           out_hi_code, out_lo_code;

    int n_checks = 0;
    int n_err = 0;
    int img [H][W];
    int exp_hi [NOUT];
    int exp_lo [NOUT];
    int exp_hc [NOUT];
    int cap_hi [64];
    int cap_lo [64];
    int cap_hc [64];
    int cap_lc [64];
    int cap_n = 0;

    always #5 clk = ~clk;

    dwt_col_lift53 #(.IMG_W(W), .IMG_H(H), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .out_valid(out_valid), .out_hi(out_hi),
        .out_lo(out_lo), .out_hi_code(out_hi_code), .out_lo_code(out_lo_code)
    );

    always @(negedge clk) begin
        if (out_valid && cap_n < 64) begin
            cap_hi[cap_n] = int'(out_hi);
            cap_lo[cap_n] = int'(out_lo);
            cap_hc[cap_n] = int'(out_hi_code);
            cap_lc[cap_n] = int'(out_lo_code);
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // model straight from the lifting equations, in output order
    task automatic build_expected();
        int d [H/2][W];
        for (int k = 0; k < H / 2; k++) begin
            for (int i = 0; i < W; i++) begin
                int bot = (2 * k + 2 < H) ? img[2*k+2][i] : img[2*k][i];
                d[k][i] = img[2*k+1][i] - ((img[2*k][i] + bot) >>> 1);
            end
        end
        for (int k = 0; k < H / 2; k++) begin
            for (int i = 0; i < W; i++) begin
                int dp = (k == 0) ? d[0][i] : d[k-1][i];
                exp_hi[k*W+i] = d[k][i];
                exp_lo[k*W+i] = img[2*k][i] + ((dp + d[k][i] + 2) >>> 2);
                exp_hc[k*W+i] = (i % 2 == 0) ? 0 : 2;
            end
        end
    endtask

    task automatic send_sample(input int v, input bit sof);
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = sof;
        in_data  = DW'(v);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sof   = 1'b0;
        end
    endtask

    task automatic send_frame(input bit gaps);
        for (int r = 0; r < H; r++) begin
            for (int i = 0; i < W; i++) begin
                send_sample(img[r][i], r == 0 && i == 0);
                if (gaps) idle(1);
            end
        end
        idle(4);
    endtask

    task automatic compare_frame(input string req);
        build_expected();
        chk(cap_n == NOUT, "R9", "result count", cap_n, NOUT);
        for (int n = 0; n < NOUT && n < cap_n; n++) begin
            chk(cap_hi[n] == exp_hi[n], req, "high value", cap_hi[n], exp_hi[n]);
            chk(cap_lo[n] == exp_lo[n], req, "low value", cap_lo[n], exp_lo[n]);
            chk(cap_hc[n] == exp_hc[n], "R8", "high code", cap_hc[n], exp_hc[n]);
            chk(cap_lc[n] == exp_hc[n] + 1, "R8", "low code", cap_lc[n], exp_hc[n] + 1);
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        // R2: stray samples with no frame started
        for (int j = 0; j < 3 * W; j++) send_sample(j * 7 - 40, 1'b0);
        idle(4);
        chk(cap_n == 0, "R2", "outputs before frame start", cap_n, 0);
    endtask

    task automatic t_flat();
        for (int r = 0; r < H; r++) for (int i = 0; i < W; i++) img[r][i] = 37;
        cap_n = 0;
        send_frame(1'b0);
        compare_frame("R4 R5");
        chk(cap_hi[0] == 0, "R4", "flat high", cap_hi[0], 0);
        chk(cap_lo[0] == 37, "R5", "flat low", cap_lo[0], 37);
    endtask

    task automatic t_ramp();
        for (int r = 0; r < H; r++) for (int i = 0; i < W; i++) img[r][i] = r * 5 + i - 3;
        cap_n = 0;
        send_frame(1'b0);
        compare_frame("R6 R7");
        chk(cap_hi[0] == 0, "R6", "first pair high", cap_hi[0], 0);
        chk(cap_lo[0] == -3, "R6", "first pair low", cap_lo[0], -3);
        chk(cap_hi[2*W] == 5, "R7", "last pair high", cap_hi[2*W], 5);
        chk(cap_lo[2*W] == 18, "R7", "last pair low", cap_lo[2*W], 18);
    endtask

    task automatic t_floor();
        for (int r = 0; r < H; r++) for (int i = 0; i < W; i++) img[r][i] = 0;
        img[2][0] = -1;
        img[4][0] = -1;
        cap_n = 0;
        send_frame(1'b0);
        compare_frame("R4 R5");
        chk(cap_hi[0] == 1, "R4", "floor of negative half", cap_hi[0], 1);
        chk(cap_lo[0] == 1, "R5", "low after floor", cap_lo[0], 1);
    endtask

    task automatic t_random_gaps();
        for (int r = 0; r < H; r++)
            for (int i = 0; i < W; i++) img[r][i] = int'($urandom % 1023) - 511;
        cap_n = 0;
        send_frame(1'b0);
        compare_frame("R4 R5");
        cap_n = 0;
        send_frame(1'b1);
        compare_frame("R10");
    endtask

    task automatic t_latency();
        for (int r = 0; r < H; r++)
            for (int i = 0; i < W; i++) img[r][i] = int'($urandom % 601) - 300;
        build_expected();
        cap_n = 0;
        for (int r = 0; r < 2; r++)
            for (int i = 0; i < W; i++) send_sample(img[r][i], r == 0 && i == 0);
        send_sample(img[2][0], 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R10", "valid one edge after", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R10", "valid two edges after", int'(out_valid), 1);
        chk(int'(out_hi) == exp_hi[0], "R10", "value two edges after", int'(out_hi), exp_hi[0]);
        for (int r = 2; r < H; r++)
            for (int i = (r == 2) ? 1 : 0; i < W; i++) send_sample(img[r][i], 1'b0);
        idle(4);
        compare_frame("R10");
    endtask

    task automatic t_ignore_and_restart();
        // abandoned partial frame: line 0 and half of line 1
        cap_n = 0;
        for (int j = 0; j < W + W / 2; j++) send_sample(300 - j * 11, j == 0);
        for (int r = 0; r < H; r++)
            for (int i = 0; i < W; i++) img[r][i] = (r * 13 + i * 29) % 97 - 48;
        send_frame(1'b0);
        compare_frame("R3");
        // R2: samples after the frame has ended
        for (int j = 0; j < 3 * W; j++) send_sample(j * 3 + 1, 1'b0);
        idle(4);
        chk(cap_n == NOUT, "R2", "outputs after frame end", cap_n, NOUT);
        cap_n = 0;
        send_frame(1'b0);
        compare_frame("R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_flat();
        t_ramp();
        t_floor();
        t_random_gaps();
        t_latency();
        t_ignore_and_restart();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule